// File: doc/BRIEF.md
# Conversion Sequence Restart Controller

This block decides when an analog conversion sequencer must start again from the first entry of its active command list. It also decides when the active and alternative command lists trade places. It keeps two flags. The restart flag asks the sequencer to reload. The load-ok flag says the alternative list is ready and must become active at the next reload.

Either flag can be requested in two ways: by a write on the register bus, or by a rising edge on the hardware restart line. A two-bit access field chooses which of these sources is obeyed. The block reports three things. It pulses an overrun output when a request arrives while a restart is still pending. It pulses a trigger output when, in trigger mode, a restart is raised at the end of a list or after an abort. It sets a sticky error flag when, in restart mode, a reload takes place without a prepared alternative list.

The block carries no data stream. Its only handshake with the sequencer is `reload_req` and `cmd_loaded`. `reload_req` is high while a restart is pending and the sequencer is idle. A high `seq_busy` acts as back-pressure and holds the request low. The reload executes in a cycle where `reload_req` and `cmd_loaded` are both high.

Top module: `seq_restart_ctrl`

## Requirements
- R1: After reset, restart_flag, loadok_flag, overrun, trig_set, ldok_err and active_sel are all 0.
- R2: A restart request sets restart_flag only while en is 1. In any cycle where en is 0, restart_flag and loadok_flag are cleared at the next clock edge.
- R3: acc_cfg selects the accepted sources. 00 accepts none, 01 accepts the bus only, 10 accepts the hardware line only, and 11 accepts both. A request from a source that is not selected changes no flag. A hardware request is a 0-to-1 edge of if_restart; holding the line high does not request again.
- R4: A bus write with bus_rst_bit = 0 changes neither flag. In particular, bus_ldok_bit = 1 on its own does not set loadok_flag, and writing zeros does not clear a set loadok_flag.
- R5: A request from an accepted source while restart_flag is already 1 leaves both flags unchanged. It makes overrun high for exactly the following cycle.
- R6: loadok_flag is set together with restart_flag when the request carries load-ok: bus_ldok_bit in the same bus write, or if_loadok sampled in the cycle of the if_restart edge.
- R7: reload_req is high exactly when restart_flag is 1 and seq_busy is 0. When cmd_loaded is high in such a cycle, restart_flag clears at the next edge.
- R8: When a reload executes with loadok_flag set, active_sel toggles and loadok_flag clears. When a reload executes without it, active_sel keeps its value.
- R9: While dbuf_en is 0, loadok_flag is 0 from the next edge on, whatever is requested.
- R10: With mode_restart = 0, trig_set pulses in the same cycle that restart_flag rises, provided eol_hit or an abort (abort_req now, or abort_req seen since the last reload) accompanies the request. Without either, trig_set stays 0.
- R11: With mode_restart = 1, a reload that executes without loadok_flag sets ldok_err. No error is set in four cases: an abort request has occurred since the last reload (or in the same cycle); the reload is the first one after en rose; it is the first one after stop_exit; or it is the first one after soft_rst.
- R12: ldok_err stays set until a bus write with bus_errclr = 1 from an accepted bus source (acc_cfg bit 0 = 1) clears it.
- R13: soft_rst clears restart_flag and loadok_flag at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Converter enable |
| dbuf_en | input | 1 | Command-list double-buffer mode |
| mode_restart | input | 1 | 1 = restart mode, 0 = trigger mode |
| acc_cfg | input | 2 | Request source select (see R3) |
| bus_wr | input | 1 | Bus write strobe for the control bits |
| bus_rst_bit | input | 1 | Written value of the restart bit |
| bus_ldok_bit | input | 1 | Written value of the load-ok bit |
| bus_errclr | input | 1 | Written 1 clears ldok_err |
| if_restart | input | 1 | Hardware restart line (rising edge requests) |
| if_loadok | input | 1 | Hardware load-ok level, sampled with restart |
| seq_busy | input | 1 | Sequencer has a conversion or sequence in progress |
| cmd_loaded | input | 1 | Sequencer loaded the first command of the list |
| eol_hit | input | 1 | End-of-list command executed or about to execute |
| abort_req | input | 1 | Sequence abort request |
| stop_exit | input | 1 | Pulse on leaving stop mode |
| soft_rst | input | 1 | Converter soft reset pulse |
| restart_flag | output | 1 | Restart pending |
| loadok_flag | output | 1 | Alternative list ready for swap |
| reload_req | output | 1 | Reload request to the sequencer |
| active_sel | output | 1 | Index of the active command list |
| overrun | output | 1 | One-cycle overrun pulse |
| trig_set | output | 1 | One-cycle trigger pulse in trigger mode |
| ldok_err | output | 1 | Sticky missing-load-ok error |

## Verification
Two events can share a cycle: a reload executing (cmd_loaded while reload_req is high) and the suppression events for the error check (abort, enable edge, stop exit, soft reset). The bench places an abort, a stop exit or a soft reset before a reload that has no load-ok. It expects ldok_err to stay 0 in each case, and to be set when none of these came first. It also places a new request in the same cycle as a pending restart, and expects an overrun pulse on the next cycle with both flags unchanged.

// File: rtl/srq_pkg.sv
package srq_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_BUS  = 2'b01,
    ACC_HW   = 2'b10,
    ACC_BOTH = 2'b11
  } acc_e;

  typedef struct packed {
    logic hit;
    logic ldok;
  } req_t;
endpackage

// File: rtl/srq_req_front.sv
module srq_req_front
  import srq_pkg::*;
#(
  parameter bit HW_EDGE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] acc_cfg,
  input  logic       bus_wr,
  input  logic       bus_rst_bit,
  input  logic       bus_ldok_bit,
  input  logic       if_restart,
  input  logic       if_loadok,
  output req_t       req
);
  logic hw_pulse;
  logic bus_hit;
  logic hw_hit;

  generate
    if (HW_EDGE) begin : g_edge
      logic hw_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hw_q <= 1'b0;
        else        hw_q <= if_restart;
      end
      assign hw_pulse = if_restart & ~hw_q;
    end else begin : g_level
      assign hw_pulse = if_restart;
    end
  endgenerate

  assign bus_hit  = acc_cfg[0] & bus_wr & bus_rst_bit;
  assign hw_hit   = acc_cfg[1] & hw_pulse;
  assign req.hit  = bus_hit | hw_hit;
  assign req.ldok = (bus_hit & bus_ldok_bit) | (hw_hit & if_loadok);
endmodule

// File: rtl/srq_flag_core.sv
module srq_flag_core
  import srq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic soft_rst,
  input  logic dbuf_en,
  input  logic mode_restart,
  input  req_t req,
  input  logic seq_busy,
  input  logic cmd_loaded,
  input  logic eol_hit,
  input  logic abort_any,
  output logic restart_q,
  output logic ldok_q,
  output logic sel_q,
  output logic ovr_q,
  output logic trig_q,
  output logic reload,
  output logic exec
);
  logic set_rst;

  assign reload  = restart_q & ~seq_busy;
  assign exec    = reload & cmd_loaded;
  assign set_rst = en & req.hit & ~restart_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      restart_q <= 1'b0;
      ldok_q    <= 1'b0;
      sel_q     <= 1'b0;
      ovr_q     <= 1'b0;
      trig_q    <= 1'b0;
    end else if (!en || soft_rst) begin
      restart_q <= 1'b0;
      ldok_q    <= 1'b0;
      ovr_q     <= 1'b0;
      trig_q    <= 1'b0;
    end else begin
      ovr_q  <= req.hit & restart_q;
      trig_q <= set_rst & ~mode_restart & (eol_hit | abort_any);
      if (set_rst)   restart_q <= 1'b1;
      else if (exec) restart_q <= 1'b0;
      if (!dbuf_en)                  ldok_q <= 1'b0;
      else if (set_rst && req.ldok)  ldok_q <= 1'b1;
      else if (exec)                 ldok_q <= 1'b0;
      if (exec && ldok_q && dbuf_en) sel_q <= ~sel_q;
    end
  end
endmodule

// File: rtl/srq_err_track.sv
module srq_err_track (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic soft_rst,
  input  logic stop_exit,
  input  logic abort_req,
  input  logic mode_restart,
  input  logic exec,
  input  logic ldok_now,
  input  logic err_clr,
  output logic abort_any,
  output logic err_q
);
  logic en_q;
  logic abort_pend;
  logic first_pend;
  logic err_hit;

  assign abort_any = abort_req | abort_pend;
  assign err_hit   = exec & mode_restart & ~ldok_now & ~first_pend & ~abort_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      abort_pend <= 1'b0;
      first_pend <= 1'b1;
      err_q      <= 1'b0;
    end else begin
      en_q <= en;
      if (!en || soft_rst)  abort_pend <= 1'b0;
      else if (abort_req)   abort_pend <= 1'b1;
      else if (exec)        abort_pend <= 1'b0;
      if ((en && !en_q) || stop_exit || soft_rst) first_pend <= 1'b1;
      else if (exec)                              first_pend <= 1'b0;
      if (err_hit)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/seq_restart_ctrl.sv
module seq_restart_ctrl
  import srq_pkg::*;
#(
  parameter bit HW_EDGE = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       dbuf_en,
  input  logic       mode_restart,
  input  logic [1:0] acc_cfg,
  input  logic       bus_wr,
  input  logic       bus_rst_bit,
  input  logic       bus_ldok_bit,
  input  logic       bus_errclr,
  input  logic       if_restart,
  input  logic       if_loadok,
  input  logic       seq_busy,
  input  logic       cmd_loaded,
  input  logic       eol_hit,
  input  logic       abort_req,
  input  logic       stop_exit,
  input  logic       soft_rst,
  output logic       restart_flag,
  output logic       loadok_flag,
  output logic       reload_req,
  output logic       active_sel,
  output logic       overrun,
  output logic       trig_set,
  output logic       ldok_err
);
  req_t req;
  logic exec;
  logic abort_any;
  logic err_clr;

  assign err_clr = acc_cfg[0] & bus_wr & bus_errclr;

  srq_req_front #(.HW_EDGE(HW_EDGE)) u_front (
    .clk, .rst_n, .acc_cfg, .bus_wr, .bus_rst_bit, .bus_ldok_bit,
    .if_restart, .if_loadok, .req(req)
  );

  srq_flag_core u_core (
    .clk, .rst_n, .en, .soft_rst, .dbuf_en, .mode_restart, .req(req),
    .seq_busy, .cmd_loaded, .eol_hit, .abort_any(abort_any),
    .restart_q(restart_flag), .ldok_q(loadok_flag), .sel_q(active_sel),
    .ovr_q(overrun), .trig_q(trig_set), .reload(reload_req), .exec(exec)
  );

  srq_err_track u_err (
    .clk, .rst_n, .en, .soft_rst, .stop_exit, .abort_req, .mode_restart,
    .exec(exec), .ldok_now(loadok_flag), .err_clr(err_clr),
    .abort_any(abort_any), .err_q(ldok_err)
  );
endmodule

// File: rtl/seq_restart_ctrl_chk.sv
module seq_restart_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       dbuf_en,
  input logic       mode_restart,
  input logic [1:0] acc_cfg,
  input logic       bus_wr,
  input logic       bus_errclr,
  input logic       seq_busy,
  input logic       cmd_loaded,
  input logic       soft_rst,
  input logic       restart_flag,
  input logic       loadok_flag,
  input logic       active_sel,
  input logic       overrun,
  input logic       trig_set,
  input logic       ldok_err
);
  AST_EN_LOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!restart_flag && !loadok_flag)); // R2
  AST_OVR_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(restart_flag)); // R5
  AST_RESTART_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(restart_flag) |-> $past(!en || soft_rst || (cmd_loaded && !seq_busy))); // R7
  AST_SWAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_sel != $past(active_sel)) |-> $past(loadok_flag && restart_flag && cmd_loaded && !seq_busy)); // R8
  AST_NO_LDOK_SINGLE_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    !dbuf_en |=> !loadok_flag); // R9
  AST_TRIG_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    trig_set |-> ($past(!mode_restart) && restart_flag)); // R10
  AST_ERR_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ldok_err) |-> $past(bus_wr && bus_errclr && acc_cfg[0])); // R12
endmodule

bind seq_restart_ctrl seq_restart_ctrl_chk u_chk (
  .clk, .rst_n, .en, .dbuf_en, .mode_restart, .acc_cfg, .bus_wr, .bus_errclr,
  .seq_busy, .cmd_loaded, .soft_rst, .restart_flag, .loadok_flag, .active_sel,
  .overrun, .trig_set, .ldok_err
);

// File: tb/seq_restart_ctrl_bench.sv
module seq_restart_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, dbuf_en = 1, mode_restart = 1;
  logic [1:0] acc_cfg = 2'b11;
  logic bus_wr = 0, bus_rst_bit = 0, bus_ldok_bit = 0, bus_errclr = 0;
  logic if_restart = 0, if_loadok = 0, seq_busy = 1, cmd_loaded = 0;
  logic eol_hit = 0, abort_req = 0, stop_exit = 0, soft_rst = 0;
  logic restart_flag, loadok_flag, reload_req, active_sel, overrun, trig_set, ldok_err;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  seq_restart_ctrl u_seq_restart_ctrl (.*);

  // {acc[1:0], bus_wr, bus_rst, bus_ldok, if_rst, if_ldok, exp_restart, exp_ldok}
  localparam logic [8:0] VEC [10] = '{
    9'b00_111_00_00, 9'b00_000_11_00, 9'b01_111_00_11, 9'b01_000_11_00,
    9'b10_110_00_00, 9'b10_000_10_10, 9'b11_110_00_10, 9'b11_000_11_11,
    9'b01_101_00_00, 9'b11_100_00_00
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus(input logic r, input logic l);
    bus_wr = 1; bus_rst_bit = r; bus_ldok_bit = l;
    tick();
    bus_wr = 0; bus_rst_bit = 0; bus_ldok_bit = 0;
  endtask

  task automatic exec_reload();
    cmd_loaded = 1; tick(); cmd_loaded = 0;
  endtask

  task automatic errclr();
    bus_wr = 1; bus_errclr = 1; tick(); bus_wr = 0; bus_errclr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1; tick();
    chk("R1 restart", restart_flag, 0); chk("R1 ldok", loadok_flag, 0);
    chk("R1 sel", active_sel, 0);       chk("R1 ovr", overrun, 0);
    chk("R1 trig", trig_set, 0);        chk("R1 err", ldok_err, 0);

    // access-configuration table (R3, R4, R6)
    for (int i = 0; i < 10; i++) begin
      en = 0; tick(); en = 1; tick();
      acc_cfg = VEC[i][8:7]; bus_wr = VEC[i][6]; bus_rst_bit = VEC[i][5];
      bus_ldok_bit = VEC[i][4]; if_restart = VEC[i][3]; if_loadok = VEC[i][2];
      tick();
      chk($sformatf("R3 vec%0d restart", i), restart_flag, VEC[i][1]);
      chk($sformatf("R6 vec%0d ldok", i), loadok_flag, VEC[i][0]);
      bus_wr = 0; bus_rst_bit = 0; bus_ldok_bit = 0; if_restart = 0; if_loadok = 0;
      tick();
    end

    acc_cfg = 2'b11; en = 0; tick(); en = 1; tick();
    bus(1, 1);
    chk("R6 ldok with restart", loadok_flag, 1); chk("R7 busy holds", reload_req, 0);
    bus(1, 0);
    chk("R5 ovr pulse", overrun, 1); chk("R5 restart kept", restart_flag, 1);
    chk("R5 ldok kept", loadok_flag, 1);
    tick(); chk("R5 ovr single", overrun, 0);
    bus(0, 0); chk("R4 zero write ldok", loadok_flag, 1);
    seq_busy = 0; #1; chk("R7 reload_req", reload_req, 1);
    tick(); exec_reload();
    chk("R7 restart clears", restart_flag, 0); chk("R8 swap", active_sel, 1);
    chk("R8 ldok clears", loadok_flag, 0);     chk("R11 first after en", ldok_err, 0);

    bus(1, 0); exec_reload();
    chk("R11 error", ldok_err, 1); chk("R8 no swap", active_sel, 1);
    tick(); chk("R12 sticky", ldok_err, 1);
    acc_cfg = 2'b10; errclr(); chk("R12 clr ignored", ldok_err, 1);
    acc_cfg = 2'b11; errclr(); chk("R12 clr", ldok_err, 0);

    abort_req = 1; tick(); abort_req = 0;
    bus(1, 0); exec_reload(); chk("R11 abort suppress", ldok_err, 0);
    stop_exit = 1; tick(); stop_exit = 0;
    bus(1, 0); exec_reload(); chk("R11 stop suppress", ldok_err, 0);
    bus(1, 1); soft_rst = 1; tick(); soft_rst = 0;
    chk("R13 restart", restart_flag, 0); chk("R13 ldok", loadok_flag, 0);
    bus(1, 0); exec_reload(); chk("R11 soft suppress", ldok_err, 0);

    mode_restart = 0; eol_hit = 1; bus(1, 0); eol_hit = 0;
    chk("R10 trig eol", trig_set, 1);
    tick(); chk("R10 trig single", trig_set, 0);
    exec_reload(); chk("R11 trigger mode no err", ldok_err, 0);
    bus(1, 0); chk("R10 no trig", trig_set, 0); exec_reload();
    abort_req = 1; bus(1, 0); abort_req = 0; chk("R10 trig abort", trig_set, 1);
    exec_reload(); mode_restart = 1;

    dbuf_en = 0; tick(); bus(1, 1); chk("R9 ldok blocked", loadok_flag, 0);
    exec_reload(); dbuf_en = 1;
    bus(1, 1); chk("R6 ldok set", loadok_flag, 1);
    dbuf_en = 0; tick(); chk("R9 ldok forced", loadok_flag, 0);
    dbuf_en = 1; exec_reload(); chk("R8 sel after forced", active_sel, 1);

    en = 0; bus(1, 0); chk("R2 no set when off", restart_flag, 0);
    en = 1; tick(); bus(1, 1); en = 0; tick();
    chk("R2 restart cleared", restart_flag, 0); chk("R2 ldok cleared", loadok_flag, 0);

    en = 1; tick(); acc_cfg = 2'b10;
    if_restart = 1; if_loadok = 1; tick(); if_loadok = 0;
    chk("R6 hw ldok", loadok_flag, 1);
    tick(); chk("R3 level no retrigger", overrun, 0);
    if_restart = 0; tick(); if_restart = 1; tick();
    chk("R5 hw overrun", overrun, 1); if_restart = 0; tick();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule